// File: doc/BRIEF.md
# Receive Double-Buffer Role Manager

This block keeps track of two equal receive message buffers. At any time one of them is the bus side, which the serial receiver fills byte by byte, and the other is the CPU side, which software reads. The block holds no byte storage. It drives the select that tells the storage which physical buffer is the bus side. It keeps a byte counter for each buffer, along with full flags, a CPU-ownership flag and a sticky overrun flag.

Software marks the end of its read by setting a done bit in its control register. The block accepts that request and releases the CPU-side buffer, which clears that buffer's byte count, its full flag and the ownership flag. It then answers with a one-cycle clear pulse that resets the done bit. If the bus side holds a complete frame at that moment, the roles of the two buffers are exchanged on the same edge.

A frame that completes while the CPU side is empty moves to the CPU side one cycle later. A frame that completes while the bus side is still occupied is dropped and raises the overrun flag. The select never changes while the receiver reports an active reception.

Top module: `rxsw_buf_swapper`

## Requirements
- R1: After a synchronous reset, bus_sel is 0, every flag and done_clr are 0, and both counts read 0.
- R2: Each byte_inc cycle raises bus_count by one, provided the bus side is not full. The count saturates at MAX_BYTES (default 11).
- R3: When frame_done arrives with the bus side not full, bus_full reads 1 after that edge.
- R4: A full bus side moves to the CPU side one cycle later when all of the following hold in that cycle: the CPU side is empty, rx_active is low and frame_done is low. On that move, bus_sel inverts, cpu_full and rx_cpu become 1, cpu_count takes the old bus count, and the bus side reads empty with a count of 0. While the CPU side is full, no move happens.
- R5: A done request is accepted when done_req is 1 and done_clr is 0. When it is accepted and no move happens, cpu_full, rx_cpu and cpu_count all read 0 after the edge.
- R6: A done request accepted while the bus side is full, rx_active is low and frame_done is low releases the CPU side and swaps the roles on the same edge.
- R7: done_clr is a one-cycle pulse in the cycle after acceptance. A done_req still high during that pulse is not accepted again.
- R8: While rx_active is 1, bus_sel keeps its value. A pending move waits until rx_active falls.
- R9: frame_done while the bus side is full leaves the buffers unchanged and sets overrun. Overrun stays set until an ovr_clr cycle without a new discard.
- R10: byte_inc while the bus side is full leaves bus_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | Receiver finished a frame into the bus-side buffer |
| rx_active | input | 1 | Receiver is inside a frame |
| byte_inc | input | 1 | Receiver stored one byte into the bus-side buffer |
| done_req | input | 1 | Software done bit (level, cleared via done_clr) |
| ovr_clr | input | 1 | Clears the overrun flag |
| bus_sel | output | 1 | Physical buffer index that is the bus side |
| cpu_full | output | 1 | CPU-side buffer holds a frame |
| bus_full | output | 1 | Bus-side buffer holds a complete frame |
| rx_cpu | output | 1 | CPU owns a valid received frame |
| overrun | output | 1 | Sticky: a frame was dropped |
| done_clr | output | 1 | One-cycle acknowledge that clears the done bit |
| cpu_count | output | CNT_W | Byte count of the CPU-side buffer |
| bus_count | output | CNT_W | Byte count of the bus-side buffer |

## Verification
The bench covers a done request that meets a full bus side, which must swap on the same edge, and a done request that meets an empty bus side, which must only release. A design that swapped late would show stale counts for a cycle; one that always swapped would hand an empty buffer to software. It holds done_req high through the acknowledge cycle, so a design that re-accepted it would release the freshly swapped frame. It also drives a frame completion into a full bus side and byte strobes while the bus side is full, where a wrong design would overwrite the waiting frame's count or lose the overrun. Finally it keeps rx_active high while a move is pending, to catch a select that flips in the middle of a frame.

// File: rtl/rxsw_pkg.sv
package rxsw_pkg;
  localparam int NUM_BUFS = 2;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  function automatic side_e other_side(side_e s);
    return (s == SIDE_A) ? SIDE_B : SIDE_A;
  endfunction
endpackage

// File: rtl/rxsw_byte_counter.sv
module rxsw_byte_counter #(
  parameter int MAX_COUNT = 11,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != LIMIT)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rxsw_swap_ctrl.sv
module rxsw_swap_ctrl
  import rxsw_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_done,
  input  logic                rx_active,
  input  logic                byte_inc,
  input  logic                done_req,
  input  logic                ovr_clr,
  output side_e               bus_side,
  output logic [NUM_BUFS-1:0] full,
  output logic                rx_cpu,
  output logic                overrun,
  output logic                done_clr,
  output logic [NUM_BUFS-1:0] cnt_clr,
  output logic [NUM_BUFS-1:0] cnt_inc
);
  side_e               bus_q, bus_d;
  logic [NUM_BUFS-1:0] full_q, full_d;
  logic                rxcpu_q, rxcpu_d;
  logic                ovr_q, ovr_d;
  logic                dclr_q;
  logic                accept, swap, discard;
  logic                bus_idx, cpu_idx;
  logic                bus_full_w, cpu_full_w;

  always_comb begin
    bus_idx    = 1'(bus_q);
    cpu_idx    = 1'(other_side(bus_q));
    bus_full_w = full_q[bus_idx];
    cpu_full_w = full_q[cpu_idx];
    accept     = done_req && !dclr_q;
    discard    = frame_done && bus_full_w;
    swap       = bus_full_w && !rx_active && !frame_done && (!cpu_full_w || accept);
  end

  always_comb begin
    cnt_clr = '0;
    cnt_inc = '0;
    full_d  = full_q;
    if (accept) begin
      cnt_clr[cpu_idx] = 1'b1;
      full_d[cpu_idx]  = 1'b0;
    end
    if (byte_inc && !bus_full_w) cnt_inc[bus_idx] = 1'b1;
    if (frame_done && !bus_full_w) full_d[bus_idx] = 1'b1;
    bus_d = swap ? other_side(bus_q) : bus_q;
    if (swap)        rxcpu_d = 1'b1;
    else if (accept) rxcpu_d = 1'b0;
    else             rxcpu_d = rxcpu_q;
    if (discard)      ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q   <= SIDE_A;
      full_q  <= '0;
      rxcpu_q <= 1'b0;
      ovr_q   <= 1'b0;
      dclr_q  <= 1'b0;
    end else begin
      bus_q   <= bus_d;
      full_q  <= full_d;
      rxcpu_q <= rxcpu_d;
      ovr_q   <= ovr_d;
      dclr_q  <= accept;
    end
  end

  assign bus_side = bus_q;
  assign full     = full_q;
  assign rx_cpu   = rxcpu_q;
  assign overrun  = ovr_q;
  assign done_clr = dclr_q;
endmodule

// File: rtl/rxsw_buf_swapper.sv
module rxsw_buf_swapper
  import rxsw_pkg::*;
#(
  parameter int  MAX_BYTES = 11,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_done,
  input  logic             rx_active,
  input  logic             byte_inc,
  input  logic             done_req,
  input  logic             ovr_clr,
  output logic             bus_sel,
  output logic             cpu_full,
  output logic             bus_full,
  output logic             rx_cpu,
  output logic             overrun,
  output logic             done_clr,
  output logic [CNT_W-1:0] cpu_count,
  output logic [CNT_W-1:0] bus_count
);
  side_e               bus_side;
  logic [NUM_BUFS-1:0] full;
  logic [NUM_BUFS-1:0] cnt_clr, cnt_inc;
  logic [CNT_W-1:0]    cnt [NUM_BUFS];

  rxsw_swap_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .rx_active  (rx_active),
    .byte_inc   (byte_inc),
    .done_req   (done_req),
    .ovr_clr    (ovr_clr),
    .bus_side   (bus_side),
    .full       (full),
    .rx_cpu     (rx_cpu),
    .overrun    (overrun),
    .done_clr   (done_clr),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc)
  );

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
    rxsw_byte_counter #(
      .MAX_COUNT (MAX_BYTES),
      .CNT_W     (CNT_W)
    ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (cnt_clr[g]),
      .inc   (cnt_inc[g]),
      .count (cnt[g])
    );
  end

  always_comb begin
    bus_sel   = 1'(bus_side);
    bus_full  = full[bus_sel];
    cpu_full  = full[!bus_sel];
    bus_count = cnt[bus_sel];
    cpu_count = cnt[!bus_sel];
  end
endmodule

// File: rtl/rxsw_checker.sv
module rxsw_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_done,
  input logic             rx_active,
  input logic             byte_inc,
  input logic             done_req,
  input logic             ovr_clr,
  input logic             bus_sel,
  input logic             cpu_full,
  input logic             bus_full,
  input logic             rx_cpu,
  input logic             overrun,
  input logic             done_clr,
  input logic [CNT_W-1:0] cpu_count,
  input logic [CNT_W-1:0] bus_count
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_clr |=> !done_clr);  // R7

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    rx_active |=> $stable(bus_sel));  // R8

  AST_OVR_RAISE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && bus_full) |=> overrun);  // R9

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);  // R9

  AST_OWNER_FLAG: assert property (@(posedge clk) disable iff (rst)
    rx_cpu == cpu_full);  // R4

  AST_FULL_NOCOUNT: assert property (@(posedge clk) disable iff (rst)
    (bus_full && rx_active && byte_inc) |=> $stable(bus_count));  // R10

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done_req && !done_clr && !bus_full) |=> (!cpu_full && cpu_count == '0));  // R5

  AST_SWAP_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (done_req && !done_clr && bus_full && !rx_active && !frame_done)
      |=> (bus_sel != $past(bus_sel) && cpu_full && !bus_full));  // R6
endmodule

bind rxsw_buf_swapper rxsw_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rxsw_buf_swapper_tb.sv
`timescale 1ns/100ps
module rxsw_buf_swapper_tb;
  localparam int MAXB  = 11;
  localparam int CNT_W = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_done = 0, rx_active = 0, byte_inc = 0, done_req = 0, ovr_clr = 0;
  logic bus_sel, cpu_full, bus_full, rx_cpu, overrun, done_clr;
  logic [CNT_W-1:0] cpu_count, bus_count;

  always #2.5 clk = ~clk;

  rxsw_buf_swapper #(.MAX_BYTES(MAXB)) u_dut (.*);

  typedef struct {
    int    sel, cfull, bfull, rxc, ovr, dclr, ccnt, bcnt;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0, clr_pend = 0;

  // requirement-level model, kept in terms of roles
  int m_sel = 0, m_dclr = 0, m_rxc = 0, m_ovr = 0;
  int m_full[2] = '{0, 0};
  int m_cnt[2]  = '{0, 0};

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  task automatic cyc(bit fd, bit ra, bit bi, bit oc, bit dn, string tag);
    int b, c, fire, bf, cf, sw;
    int n_full[2], n_cnt[2];
    exp_t e;
    @(negedge clk);
    if (clr_pend) begin done_req = 0; clr_pend = 0; end
    if (done_clr) clr_pend = 1;
    if (dn) done_req = 1;
    frame_done = fd; rx_active = ra; byte_inc = bi; ovr_clr = oc;
    b = m_sel; c = 1 - m_sel;
    fire = (done_req && !m_dclr) ? 1 : 0;
    bf = m_full[b]; cf = m_full[c];
    n_full = m_full; n_cnt = m_cnt;
    if (fire != 0) begin n_full[c] = 0; n_cnt[c] = 0; end
    if (bi && bf == 0 && m_cnt[b] < MAXB) n_cnt[b] = m_cnt[b] + 1;
    if (fd && bf == 0) n_full[b] = 1;
    sw = (bf != 0 && !ra && !fd && (cf == 0 || fire != 0)) ? 1 : 0;
    if (fd && bf != 0) m_ovr = 1;
    else if (oc)       m_ovr = 0;
    if (sw != 0)        m_rxc = 1;
    else if (fire != 0) m_rxc = 0;
    if (sw != 0) m_sel = 1 - m_sel;
    m_dclr = fire;
    m_full = n_full; m_cnt = n_cnt;
    e.sel = m_sel; e.cfull = m_full[1-m_sel]; e.bfull = m_full[m_sel];
    e.rxc = m_rxc; e.ovr = m_ovr; e.dclr = m_dclr;
    e.ccnt = m_cnt[1-m_sel]; e.bcnt = m_cnt[m_sel]; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare just after each active edge
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "bus_sel",   int'(bus_sel),   e.sel);
      chk(e.tag, "cpu_full",  int'(cpu_full),  e.cfull);
      chk(e.tag, "bus_full",  int'(bus_full),  e.bfull);
      chk(e.tag, "rx_cpu",    int'(rx_cpu),    e.rxc);
      chk(e.tag, "overrun",   int'(overrun),   e.ovr);
      chk(e.tag, "done_clr",  int'(done_clr),  e.dclr);
      chk(e.tag, "cpu_count", int'(cpu_count), e.ccnt);
      chk(e.tag, "bus_count", int'(bus_count), e.bcnt);
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1", "bus_sel",   int'(bus_sel), 0);
    chk("R1", "flags",     int'({cpu_full, bus_full, rx_cpu, overrun, done_clr}), 0);
    chk("R1", "counts",    int'(cpu_count) + int'(bus_count), 0);
    cyc(0, 0, 0, 0, 0, "R1");
    // R2 counting bytes of a frame
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, "R2");
    // R3 completion, then R4 move to empty CPU side
    cyc(1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R4");
    // second frame of 5 bytes stays on bus side: CPU side occupied
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R4");
    // R10 bytes while bus side full
    cyc(0, 1, 1, 0, 0, "R10");
    cyc(0, 1, 1, 0, 0, "R10");
    // R9 overrun and clear
    cyc(1, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 0, "R9");
    // R6 done with full bus side swaps on same edge; R7 held done_req
    cyc(0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R7");
    // R5 done with empty bus side releases only
    cyc(0, 0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, "R5");
    // R2 saturation
    for (int i = 0; i < MAXB + 3; i++) cyc(0, 1, 1, 0, 0, "R2");
    // R8 move held while rx_active high
    cyc(1, 1, 0, 0, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R4");
    // R8 done during reception with full bus side: release only, swap later
    for (int i = 0; i < 2; i++) cyc(0, 1, 1, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, "R3");
    cyc(0, 1, 0, 0, 1, "R8");
    cyc(0, 1, 0, 0, 0, "R8");
    cyc(0, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R4");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule